// File: doc/BRIEF.md
# ROM Patch Overlay Unit

The unit sits on the read path between a read-only program memory and the bus that reads it. It holds a table of patch slots. Each slot has an enable bit, a word address to match and one 32-bit replacement word. Every read request is compared with all enabled slots in the same cycle that the request goes to the memory. When a slot matches, the unit returns that slot's replacement word in place of the memory data. Instruction fetches and data loads use the same path, so every reader sees the patched contents. A typical replacement word is a 4-byte branch that sends execution from ROM into RAM.

The memory answers one cycle after a request. The unit registers its hit decision and the selected replacement word at the request, so they arrive in the same cycle as the memory data. A small read-stage state machine tracks the response cycle. Its state `RS_IDLE` moves to `RS_RESP` when a request is present. `RS_RESP` stays in `RS_RESP` on a back-to-back request and returns to `RS_IDLE` otherwise. Software programs the table through a write port. Each write carries a slot index, a field selector and a data word.

Top module: `rpo_overlay_top`

## Requirements
- R1: After reset every slot is disabled. Every read returns the memory word unchanged, and `bus_rvalid` is low while reset is held.
- R2: A read whose word address equals that of an enabled slot returns that slot's replacement word. The returned word appears with `bus_rvalid` one cycle after the request. A read of a neighbouring word returns memory data.
- R3: Byte-address bits [1:0] take no part in matching, on both the read address and the programmed address. All four byte addresses of a patched word return the replacement.
- R4: A disabled slot never changes read data. This holds whether the slot was never enabled or was enabled and then cleared.
- R5: When several enabled slots hold the same address, the slot with the lowest index supplies the data.
- R6: A table write in cycle t affects a read requested in cycle t+1 or later. A read requested in cycle t itself sees the table as it was before the write.
- R7: The field selector encodes 0 = match address (write data bits [ADDR_W-1:2]), 1 = replacement word, 2 = enable (write data bit 0), and 3 = reserved. A write with selector 3 changes nothing.
- R8: `rom_addr` and `rom_en` follow `bus_addr` and `bus_req` in the same cycle. Requests on consecutive cycles give one response per cycle, in order.
- R9: The slot with the highest index (NUM_SLOTS-1, default 128 slots, 256 as the larger option) and the highest word address match like any other slot.
- R10: A cycle without a request is followed by a cycle with `bus_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Read request from the bus |
| bus_addr | input | ADDR_W | Byte address of the read |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Patched or memory read data |
| rom_en | output | 1 | Read enable to the program memory |
| rom_addr | output | ADDR_W | Address to the program memory |
| rom_rdata | input | 32 | Memory data, one cycle after `rom_en` |
| prog_we | input | 1 | Table write strobe |
| prog_slot | input | IDX_W | Slot index of the write |
| prog_field | input | 2 | Field selector (see R7) |
| prog_wdata | input | 32 | Write data |

## Verification
The assertions check on every cycle that a response follows each request and that no response follows an idle cycle. They check that a returned word is either the registered replacement or the untouched memory word. They also check that the chosen slot is a hit with no lower-indexed hit beside it, that a reserved write leaves the enables unchanged, and that the enables are clear when reset is released. Some behaviour needs the bench's scenarios to show it. That covers ignoring the low address bits, ordering a write against a read in the same cycle, switching priority when the winning slot is disabled, and the last slot at the top of the address space. The bench checks these at the ports against its own model of the table.

// File: rtl/rpo_pkg.sv
`timescale 1ns/1ps
package rpo_pkg;

    localparam int WORD_W = 32;

    // Field selector of the programming port.
    typedef enum logic [1:0] {
        FLD_MATCH = 2'd0,
        FLD_REPL  = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_RSVD  = 2'd3
    } prog_field_e;

    // Read-stage states.
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/rpo_slot_table.sv
`timescale 1ns/1ps
module rpo_slot_table
    import rpo_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    parameter int ADDR_W    = 24,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_slot,
    input  logic [1:0]        prog_field,
    input  logic [WORD_W-1:0] prog_wdata,
    output logic [NUM_SLOTS-1:0] slot_en,
    output logic [WA_W-1:0]   slot_waddr [NUM_SLOTS],
    output logic [WORD_W-1:0] slot_data  [NUM_SLOTS]
);

    prog_field_e fld;
    assign fld = prog_field_e'(prog_field);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit_wr;
        assign hit_wr = prog_we && (prog_slot == IDX_W'(s));

        // Enable bits are the only reset state: a cleared table passes ROM data.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_en[s] <= 1'b0;
            end else if (hit_wr && fld == FLD_CTRL) begin
                slot_en[s] <= prog_wdata[0];
            end
        end

        // Address and replacement storage carry no reset.
        always_ff @(posedge clk) begin
            if (hit_wr) begin
                unique case (fld)
                    FLD_MATCH: slot_waddr[s] <= prog_wdata[ADDR_W-1:2];
                    FLD_REPL:  slot_data[s]  <= prog_wdata;
                    FLD_CTRL:  ;
                    FLD_RSVD:  ;
                endcase
            end
        end
    end

    AST_ENABLES_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> slot_en == '0); // R1

    AST_RSVD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && prog_field == 2'd3) |=> $stable(slot_en)); // R7

endmodule

// File: rtl/rpo_match.sv
`timescale 1ns/1ps
module rpo_match
    import rpo_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    parameter int ADDR_W    = 24,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SLOTS-1:0] slot_en,
    input  logic [WA_W-1:0]   slot_waddr [NUM_SLOTS],
    input  logic [WORD_W-1:0] slot_data  [NUM_SLOTS],
    input  logic [WA_W-1:0]   req_waddr,
    output logic              any_hit,
    output logic [WORD_W-1:0] hit_data
);

    localparam logic [NUM_SLOTS-1:0] ONE_V = {{(NUM_SLOTS-1){1'b0}}, 1'b1};

    logic [NUM_SLOTS-1:0] hit_vec;
    logic [IDX_W-1:0]     sel;
    logic [NUM_SLOTS-1:0] below_mask;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        assign hit_vec[s] = slot_en[s] && (slot_waddr[s] == req_waddr);
    end

    // Walk from the top down so the lowest hit is the one that stays.
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel     = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    assign hit_data   = slot_data[sel];
    assign below_mask = (ONE_V << sel) - ONE_V;

    AST_SEL_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[sel]); // R5

    AST_SEL_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec & below_mask) == '0); // R5

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> slot_en[sel]); // R4

    AST_EMPTY_TABLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en == '0) |-> !any_hit); // R1

endmodule

// File: rtl/rpo_read_stage.sv
`timescale 1ns/1ps
module rpo_read_stage
    import rpo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              any_hit,
    input  logic [WORD_W-1:0] hit_data,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic              bus_rvalid,
    output logic [WORD_W-1:0] bus_rdata
);

    rd_state_e state_q, state_d;
    logic              hit_q;
    logic [WORD_W-1:0] repl_q;

    always_comb begin
        unique case (state_q)
            RS_IDLE: state_d = bus_req ? RS_RESP : RS_IDLE;
            RS_RESP: state_d = bus_req ? RS_RESP : RS_IDLE;
        endcase
    end

    // State register and the registered hit decision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bus_req) hit_q <= any_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (bus_req) repl_q <= hit_data;
    end

    // Outputs.
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            RS_IDLE: ;
            RS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = hit_q ? repl_q : rom_rdata;
            end
        endcase
    end

    AST_RVALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_rvalid); // R8

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rvalid); // R10

    AST_HIT_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(any_hit)) |-> bus_rdata == $past(hit_data)); // R2

    AST_MISS_PASSES_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && !$past(any_hit)) |-> bus_rdata == rom_rdata); // R4

endmodule

// File: rtl/rpo_overlay_top.sv
`timescale 1ns/1ps
module rpo_overlay_top
    import rpo_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    parameter int ADDR_W    = 24,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rvalid,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              rom_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_rdata,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_slot,
    input  logic [1:0]        prog_field,
    input  logic [WORD_W-1:0] prog_wdata
);

    logic [NUM_SLOTS-1:0] slot_en;
    logic [WA_W-1:0]      slot_waddr [NUM_SLOTS];
    logic [WORD_W-1:0]    slot_data  [NUM_SLOTS];
    logic                 any_hit;
    logic [WORD_W-1:0]    hit_data;

    assign rom_en   = bus_req;
    assign rom_addr = bus_addr;

    rpo_slot_table #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_slot  (prog_slot),
        .prog_field (prog_field),
        .prog_wdata (prog_wdata),
        .slot_en    (slot_en),
        .slot_waddr (slot_waddr),
        .slot_data  (slot_data)
    );

    rpo_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .slot_waddr (slot_waddr),
        .slot_data  (slot_data),
        .req_waddr  (bus_addr[ADDR_W-1:2]),
        .any_hit    (any_hit),
        .hit_data   (hit_data)
    );

    rpo_read_stage read_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .any_hit    (any_hit),
        .hit_data   (hit_data),
        .rom_rdata  (rom_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: tb/rpo_overlay_top_tb_top.sv
`timescale 1ns/1ps
module rpo_overlay_top_tb_top;

    localparam int NS   = 128;
    localparam int AW   = 24;
    localparam int IW   = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic          rom_en;
    logic [AW-1:0] rom_addr;
    logic [31:0]   rom_q = '0;
    logic          prog_we = 1'b0;
    logic [IW-1:0] prog_slot = '0;
    logic [1:0]    prog_field = '0;
    logic [31:0]   prog_wdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        m_en  [NS];
    logic [21:0] m_wa  [NS];
    logic [31:0] m_dat [NS];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    rpo_overlay_top #(.NUM_SLOTS(NS), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .rom_en(rom_en),
        .rom_addr(rom_addr), .rom_rdata(rom_q), .prog_we(prog_we),
        .prog_slot(prog_slot), .prog_field(prog_field), .prog_wdata(prog_wdata)
    );

    function automatic logic [31:0] rom_fn(input logic [21:0] wa);
        return (32'(wa) * 32'h9E37_79B1) ^ 32'hA500_00C3;
    endfunction

    // Bench ROM: one cycle of read latency.
    always @(posedge clk) if (rom_en) rom_q <= rom_fn(rom_addr[AW-1:2]);

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
        for (int i = 0; i < NS; i++)
            if (m_en[i] && m_wa[i] == a[AW-1:2]) return m_dat[i];
        return rom_fn(a[AW-1:2]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic model_write(input int s, input logic [1:0] f, input logic [31:0] d);
        case (f)
            2'd0: m_wa[s]  = d[AW-1:2];
            2'd1: m_dat[s] = d;
            2'd2: m_en[s]  = d[0];
            default: ;
        endcase
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0;
        prog_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        prog_we  = 1'b0;
        bus_req  = 1'b1;
        bus_addr = a;
        exp_q.push_back(exp_word(a));
        tag_q.push_back(tag);
        #1;
        chk(rom_addr == a && rom_en, "R8 rom_addr", 32'(rom_addr), 32'(a));
    endtask

    task automatic prog(input int s, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        bus_req    = 1'b0;
        prog_we    = 1'b1;
        prog_slot  = IW'(s);
        prog_field = f;
        prog_wdata = d;
        model_write(s, f, d);
    endtask

    task automatic set_slot(input int s, input logic [AW-1:0] a, input logic [31:0] d, input bit en);
        prog(s, 2'd0, 32'(a));
        prog(s, 2'd1, d);
        prog(s, 2'd2, {31'd0, en});
    endtask

    // Write and read issued in the same cycle: the read sees the old table.
    task automatic prog_rd(input int s, input logic [1:0] f, input logic [31:0] d,
                           input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        prog_we    = 1'b1;
        prog_slot  = IW'(s);
        prog_field = f;
        prog_wdata = d;
        bus_req    = 1'b1;
        bus_addr   = a;
        exp_q.push_back(exp_word(a));
        tag_q.push_back(tag);
        model_write(s, f, d);
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 1'b0; m_wa[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(bus_rvalid == 1'b0, "R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
        rst_n = 1'b1;

        // R1: empty table passes ROM data.
        rd(24'h000100, "R1 pass-through a");
        rd(24'h001000, "R1 pass-through b");
        rd(24'hFFFFFC, "R1 pass-through c");
        idle();

        // R2: basic hit and neighbour miss.
        set_slot(5, 24'h001000, 32'hF000_B800, 1'b1);
        rd(24'h001000, "R2 hit slot5");
        rd(24'h001004, "R2 neighbour miss");
        rd(24'h000FFC, "R2 lower neighbour miss");
        idle();

        // R3: low address bits ignored on both sides.
        rd(24'h001001, "R3 byte1");
        rd(24'h001002, "R3 byte2");
        rd(24'h001003, "R3 byte3");
        set_slot(7, 24'h002003, 32'h1234_5678, 1'b1);
        rd(24'h002000, "R3 programmed low bits");
        idle();

        // R4: disabled slots do nothing.
        set_slot(6, 24'h003000, 32'hDEAD_BEEF, 1'b0);
        rd(24'h003000, "R4 never enabled");
        prog(5, 2'd2, 32'h0);
        rd(24'h001000, "R4 cleared slot5");
        idle();

        // R5: lowest index wins.
        set_slot(10, 24'h004000, 32'hAAAA_0010, 1'b1);
        set_slot(3,  24'h004000, 32'hAAAA_0003, 1'b1);
        rd(24'h004000, "R5 slot3 over slot10");
        prog(3, 2'd2, 32'h0);
        rd(24'h004000, "R5 slot10 after slot3 off");
        idle();

        // R7: reserved selector changes nothing.
        prog(10, 2'd3, 32'h0000_0000);
        prog(10, 2'd3, 32'h5555_5555);
        rd(24'h004000, "R7 reserved write ignored");
        idle();

        // R6: write and read ordering.
        prog_rd(10, 2'd1, 32'hBBBB_0010, 24'h004000, "R6 same-cycle read sees old");
        rd(24'h004000, "R6 next-cycle read sees new");
        prog(3, 2'd2, 32'h1);
        rd(24'h004000, "R6 re-enable seen next cycle");
        idle();

        // R9: highest slot at the top address.
        set_slot(NS - 1, 24'hFFFFFC, 32'hCAFE_F00D, 1'b1);
        rd(24'hFFFFFF, "R9 last slot top address");

        // R8: back-to-back mixed hit/miss.
        rd(24'h004000, "R8 b2b hit");
        rd(24'h000200, "R8 b2b miss");
        rd(24'h002002, "R8 b2b hit slot7");
        rd(24'hFFFFFC, "R8 b2b hit last");

        // R10: idle cycle gives no response.
        idle();
        idle();
        @(negedge clk);
        chk(bus_rvalid == 1'b0, "R10 no response after idle", 32'(bus_rvalid), 32'h0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all responses seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule